// File: doc/BRIEF.md
# Supply-Fail Reset Sequencer

This block produces the active-low reset for a microcontroller from a digital supply-good flag. The flag comes from an external comparator and is asynchronous to the block clock. The block first brings the flag into the clock domain. A drop of the flag then has to last a minimum number of clocks before it counts as a real supply failure. Shorter drops are treated as noise and do not disturb a running system.

After a real failure the reset stays low while the supply is bad. When the supply comes back, the reset stays low for a full hold-off period counted in timebase ticks, and only then is released. A status output is high while the hold-off period runs. A one-clock pulse marks each release, so that a companion watchdog can open its first window at that point.

Every qualified failure, whether it happens during normal running or during an unfinished hold-off, starts the hold-off period again from zero once the supply recovers.

Top module: `rstseq_top`

## Requirements
- R1: While `rst` is high, and on the clock edges after it, `mcu_rst_n`, `delay_busy` and `release_pulse` are all 0. They stay 0 until a good supply has been seen.
- R2: `supply_ok_raw` passes through two flip-flops before any use. After the input rises while the block is in the failed state, `delay_busy` goes to 1 on the 4th rising edge, counting the first edge that samples the new level as edge 1.
- R3: A low level on `supply_ok_raw` that is sampled on fewer than `REACT_CLKS` consecutive edges is ignored. A released `mcu_rst_n` stays 1.
- R4: A low level sampled on `REACT_CLKS` consecutive edges is a qualified failure. `mcu_rst_n` and `delay_busy` go to 0 on edge `REACT_CLKS`+3, counting the first low sample as edge 1, and stay 0 while the supply stays low.
- R5: During the hold-off, `delay_busy` is 1 and `mcu_rst_n` is 0. `mcu_rst_n` goes to 1, and `delay_busy` to 0, on the edge that samples the `DELAY_TICKS`-th `tick` after `delay_busy` rose. The default `DELAY_TICKS` is 64.
- R6: A qualified failure during the hold-off aborts it, setting `delay_busy` to 0. The next recovery counts a complete new hold-off of `DELAY_TICKS` ticks.
- R7: `release_pulse` is 1 for exactly one clock, on the edge where `mcu_rst_n` rises, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timebase strobe, one clock wide, counted by the hold-off timer |
| supply_ok_raw | input | 1 | Asynchronous comparator flag, 1 = supply above threshold |
| mcu_rst_n | output | 1 | Active-low microcontroller reset, registered |
| delay_busy | output | 1 | High while the post-recovery hold-off runs |
| release_pulse | output | 1 | One-clock strobe when reset is released |

## Verification
Every output is registered, so each result has a fixed latency from its input:
- A failure shows on the reset line at edge `REACT_CLKS`+3 of the low run.
- A recovery raises the busy flag at edge 4.
- Release coincides with the edge that samples the last counted tick.

Inputs change only on falling edges, and outputs are read on falling edges. The directed checks therefore count whole clocks from the stimulus to the exact edge where the requirement places the change. They probe the cycle before that edge as well. A cycle model in the bench, advanced on every rising edge, provides the expected value of all three outputs for every clock of the random supply and tick patterns.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

  // Sequencer phases: failed supply, hold-off running, released.
  typedef enum logic [1:0] {
    SEQ_DOWN  = 2'd0,
    SEQ_DELAY = 2'd1,
    SEQ_RUN   = 2'd2
  } seq_state_t;

endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  // Resets to "supply bad" so nothing is released before real samples arrive.
  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/rstseq_dip_filter.sv
module rstseq_dip_filter #(
  parameter int REACT_CLKS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic sup_ok,
  output logic dip_qual
);

  localparam int CW = $clog2(REACT_CLKS + 1);
  localparam logic [CW-1:0] LAST = CW'(REACT_CLKS - 1);

  logic [CW-1:0] low_cnt;

  // Low samples accumulate; any high sample clears the run at once.
  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt  <= '0;
      dip_qual <= 1'b1;
    end else if (sup_ok) begin
      low_cnt  <= '0;
      dip_qual <= 1'b0;
    end else if (!dip_qual) begin
      if (low_cnt == LAST) dip_qual <= 1'b1;
      else                 low_cnt  <= low_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/rstseq_delay_timer.sv
module rstseq_delay_timer #(
  parameter int DELAY_TICKS = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic tick,
  output logic expire
);

  localparam int CW = $clog2(DELAY_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(DELAY_TICKS - 1);

  logic [CW-1:0] tick_cnt;

  assign expire = !clr && tick && (tick_cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr)  tick_cnt <= '0;
    else if (expire) tick_cnt <= '0;
    else if (tick)   tick_cnt <= tick_cnt + 1'b1;
  end

endmodule

// File: rtl/rstseq_top.sv
module rstseq_top #(
  parameter int REACT_CLKS  = 8,
  parameter int DELAY_TICKS = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic supply_ok_raw,
  output logic mcu_rst_n,
  output logic delay_busy,
  output logic release_pulse
);
  import rstseq_pkg::*;

  logic       sup_sync;
  logic       dip_qual;
  logic       hold_expire;
  seq_state_t state_q;
  seq_state_t state_d;

  rstseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (supply_ok_raw),
    .q   (sup_sync)
  );

  rstseq_dip_filter #(.REACT_CLKS(REACT_CLKS)) u_filt (
    .clk      (clk),
    .rst      (rst),
    .sup_ok   (sup_sync),
    .dip_qual (dip_qual)
  );

  rstseq_delay_timer #(.DELAY_TICKS(DELAY_TICKS)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .clr    (state_q != SEQ_DELAY),
    .tick   (tick),
    .expire (hold_expire)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_DOWN:  if (!dip_qual) state_d = SEQ_DELAY;
      SEQ_DELAY: begin
        if (dip_qual)         state_d = SEQ_DOWN;
        else if (hold_expire) state_d = SEQ_RUN;
      end
      SEQ_RUN:   if (dip_qual) state_d = SEQ_DOWN;
      default:   state_d = SEQ_DOWN;
    endcase
  end

  // Outputs are registered from the next state so they align with state_q.
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= SEQ_DOWN;
      mcu_rst_n     <= 1'b0;
      delay_busy    <= 1'b0;
      release_pulse <= 1'b0;
    end else begin
      state_q       <= state_d;
      mcu_rst_n     <= (state_d == SEQ_RUN);
      delay_busy    <= (state_d == SEQ_DELAY);
      release_pulse <= (state_q == SEQ_DELAY) && (state_d == SEQ_RUN);
    end
  end

endmodule

// File: rtl/rstseq_checker.sv
module rstseq_checker #(
  parameter int REACT_CLKS = 8
) (
  input logic clk,
  input logic rst,
  input logic sup_sync,
  input logic dip_qual,
  input logic mcu_rst_n,
  input logic delay_busy,
  input logic release_pulse
);

  int low_run;

  // Independent count of consecutive low synchronized samples.
  always_ff @(posedge clk) begin
    if (rst)                      low_run <= 0;
    else if (sup_sync)            low_run <= 0;
    else if (low_run < REACT_CLKS) low_run <= low_run + 1;
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!mcu_rst_n && !delay_busy && !release_pulse));

  a_r3_no_early_qual: assert property (@(posedge clk) disable iff (rst)
    $rose(dip_qual) |-> (low_run >= REACT_CLKS));

  a_r4_fail_forces_reset: assert property (@(posedge clk) disable iff (rst)
    dip_qual |=> (!mcu_rst_n && !delay_busy));

  a_r5_busy_holds_reset: assert property (@(posedge clk) disable iff (rst)
    delay_busy |-> !mcu_rst_n);

  a_r7_pulse_on_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(mcu_rst_n) |-> release_pulse);

  a_r7_pulse_only_rise: assert property (@(posedge clk) disable iff (rst)
    release_pulse |-> (mcu_rst_n && $past(!mcu_rst_n)));

endmodule

bind rstseq_top rstseq_checker #(.REACT_CLKS(REACT_CLKS)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .sup_sync      (sup_sync),
  .dip_qual      (dip_qual),
  .mcu_rst_n     (mcu_rst_n),
  .delay_busy    (delay_busy),
  .release_pulse (release_pulse)
);

// File: tb/rstseq_top_bench.sv
module rstseq_top_bench;

  localparam int REACT = 5;
  localparam int DELAY = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic supply = 1'b0;
  logic mcu_rst_n, delay_busy, release_pulse;

  int vectors = 0;
  int fails   = 0;
  bit started = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  rstseq_top #(.REACT_CLKS(REACT), .DELAY_TICKS(DELAY), .SYNC_STAGES(2)) u_rstseq_top (
    .clk           (clk),
    .rst           (rst),
    .tick          (tick),
    .supply_ok_raw (supply),
    .mcu_rst_n     (mcu_rst_n),
    .delay_busy    (delay_busy),
    .release_pulse (release_pulse)
  );

  // Requirement-level model: phase 0 failed, 1 hold-off, 2 released.
  int m_p1 = 0, m_p2 = 0, m_low = 0, m_qual = 1, m_phase = 0, m_ticks = 0;
  int e_rst_n = 0, e_busy = 0, e_pulse = 0;

  function automatic int next_phase(int ph, int q, int tick_last);
    if (q != 0) return 0;
    if (ph == 0) return 1;
    if (ph == 1 && tick_last != 0) return 2;
    return ph;
  endfunction

  always @(posedge clk) begin
    started <= 1;
    if (rst) begin
      m_p1 <= 0; m_p2 <= 0; m_low <= 0; m_qual <= 1;
      m_phase <= 0; m_ticks <= 0;
      e_rst_n <= 0; e_busy <= 0; e_pulse <= 0;
    end else begin
      int lr, np;
      lr = (m_p2 != 0) ? 0 : m_low + 1;
      np = next_phase(m_phase, m_qual, int'(tick && m_ticks == DELAY - 1));
      m_p1    <= int'(supply);
      m_p2    <= m_p1;
      m_low   <= (lr > REACT) ? REACT : lr;
      m_qual  <= (m_p2 != 0) ? 0 : int'(m_qual != 0 || lr >= REACT);
      m_ticks <= (m_phase == 1 && tick) ? m_ticks + 1 : (m_phase == 1 ? m_ticks : 0);
      m_phase <= np;
      e_rst_n <= int'(np == 2);
      e_busy  <= int'(np == 1);
      e_pulse <= int'(m_phase == 1 && np == 2);
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the model (R4 R5 R6 R7 timing).
  always @(negedge clk) begin
    if (started) begin
      chk(mcu_rst_n === e_rst_n[0], {cur_req, " model mcu_rst_n"}, int'(mcu_rst_n), e_rst_n);
      chk(delay_busy === e_busy[0], {cur_req, " model delay_busy"}, int'(delay_busy), e_busy);
      chk(release_pulse === e_pulse[0], {cur_req, " model release_pulse"}, int'(release_pulse), e_pulse);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // Drives tick every clock and returns the number of ticks to release.
  task automatic measure_hold(output int n);
    n = 0;
    tick = 1'b1;
    do begin
      cyc(1);
      n++;
    end while (!mcu_rst_n && n < 4 * DELAY);
  endtask

  initial begin
    int n;
    bit stayed;
    void'($urandom(32'd4242));
    cyc(3);
    cur_req = "R1";
    chk(!mcu_rst_n && !delay_busy && !release_pulse, "R1 outputs in reset",
        int'({mcu_rst_n, delay_busy, release_pulse}), 0);
    rst = 1'b0;
    cyc(6);
    chk(!mcu_rst_n && !delay_busy, "R1 held with supply low",
        int'({mcu_rst_n, delay_busy}), 0);

    // Recovery latency through the synchronizer.
    cur_req = "R2";
    supply = 1'b1;
    cyc(3);
    chk(delay_busy == 1'b0, "R2 busy before edge 4", int'(delay_busy), 0);
    cyc(1);
    chk(delay_busy == 1'b1, "R2 busy at edge 4", int'(delay_busy), 1);

    cur_req = "R5";
    measure_hold(n);
    chk(n == DELAY, "R5 ticks in hold-off", n, DELAY);
    chk(release_pulse == 1'b1, "R7 pulse at release", int'(release_pulse), 1);
    cyc(1);
    chk(release_pulse == 1'b0, "R7 pulse one clock", int'(release_pulse), 0);

    // Short dip: one sample below the qualification length.
    cur_req = "R3";
    supply = 1'b0;
    cyc(REACT - 1);
    supply = 1'b1;
    stayed = 1;
    for (int i = 0; i < 10; i++) begin
      cyc(1);
      if (!mcu_rst_n) stayed = 0;
    end
    chk(stayed, "R3 short dip ignored", int'(stayed), 1);

    // Qualifying dip: fall exactly on edge REACT+3.
    cur_req = "R4";
    supply = 1'b0;
    cyc(REACT + 2);
    chk(mcu_rst_n == 1'b1, "R4 still released before edge", int'(mcu_rst_n), 1);
    cyc(1);
    chk(mcu_rst_n == 1'b0 && delay_busy == 1'b0, "R4 reset on qualified dip",
        int'({mcu_rst_n, delay_busy}), 0);
    cyc(8);
    chk(mcu_rst_n == 1'b0, "R4 held while supply low", int'(mcu_rst_n), 0);

    // Dip inside the hold-off restarts it completely.
    cur_req = "R6";
    supply = 1'b1;
    cyc(4);
    chk(delay_busy == 1'b1, "R6 hold-off started", int'(delay_busy), 1);
    tick = 1'b1;
    cyc(DELAY / 2);
    supply = 1'b0;
    cyc(REACT + 4);
    chk(delay_busy == 1'b0 && mcu_rst_n == 1'b0, "R6 hold-off aborted",
        int'({mcu_rst_n, delay_busy}), 0);
    supply = 1'b1;
    cyc(4);
    measure_hold(n);
    chk(n == DELAY, "R6 full hold-off after restart", n, DELAY);

    // Random supply and tick patterns against the model.
    cur_req = "R3 R4 R5 R6 R7";
    for (int seg = 0; seg < 220; seg++) begin
      int len;
      supply = ~supply;
      len = supply ? 1 + int'($urandom % (DELAY * 3)) : 1 + int'($urandom % (REACT * 3));
      for (int k = 0; k < len; k++) begin
        tick = ($urandom % 3) == 0;
        cyc(1);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule